// File: doc/BRIEF.md
# Splitter Control Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C) that holds the eight-byte configuration bank of a one-input, two-output video splitter. It samples the SCL and SDA pins with the system clock. It cleans them with a two-flop synchroniser and a short stability filter, then detects START and STOP conditions. It only answers when the seven-bit device address matches.

On a write, the first byte after the address loads a three-bit register pointer. Each later byte is stored at the pointer, and the pointer then advances, wrapping from 7 back to 0. A read returns bytes starting at the current pointer, and the pointer advances after each byte. The eight registers are presented side by side on one flat output bus, which feeds the splitter's control decoder. That decoder interprets the fields, for example:
- the equaliser code and squelch bit in register 1;
- termination, pre-emphasis, swing and slew for each output port in registers 3 and 4.

The block does not stretch the clock, answer general call or take ten-bit addresses.

Top module: `vsplit_i2c_regs`

## Requirements
- R1: After reset, the register bytes hold 0: 0xFF, 6: 0x0F and 0x00 everywhere else, and SDA is not driven. Byte n appears on `regs_o[8n+7:8n]`.
- R2: The block drives an acknowledge only when the address byte's upper seven bits equal binary 101 followed by `strap_i[3:0]`, most significant bit first, with R/W as bit 0 (1 = read). Any other address gets no acknowledge, and the block ignores the bus until the next START.
- R3: On a write, the first byte after the address sets the pointer to its low three bits. Each later byte is written to the register at the pointer, and the pointer then advances, wrapping from 7 to 0. Every one of these bytes is acknowledged.
- R4: On a read, the block returns the register at the pointer, most significant bit first, and advances the pointer (wrapping 7 to 0) after each byte. It keeps sending while the controller acknowledges. After a not-acknowledge, it releases SDA and stays silent.
- R5: A STOP ends any transfer, including one in the middle of a byte; a partly received byte is not written. A repeated START begins a new address phase without a STOP.
- R6: A pulse on SCL or SDA shorter than `FILT_LEN` clock cycles (3 by default) has no effect on the transfer.
- R7: Register contents change only on the completion of a write data byte that follows a matching address. Neither an offset byte alone nor a read changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_i | input | 4 | Low four bits of the device address |
| regs_o | output | 64 | Register bank, byte n at bits 8n+7:8n |

## Verification
A wrong pointer shows up at the ports at once: the next data byte lands in the wrong place in `regs_o`, or the next read byte carries the wrong value. The per-clock comparison of `regs_o` flags this a few cycles after the SCL edge that ends the byte. A mistaken address decision shows up in the acknowledge slot of the same byte, as a missing or spurious low on SDA. A broken START/STOP detector or glitch filter tends to shift the bit count. That corrupts the acknowledge or the stored byte within one frame.

// File: rtl/vsplit_i2c_regs.sv
module vsplit_i2c_regs #(
  parameter int FILT_LEN = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [3:0]  strap_i,
  output logic [63:0] regs_o
);
  localparam int          CW      = $clog2(FILT_LEN + 1);
  localparam int          NREG    = 8;
  localparam logic [63:0] RST_IMG = 64'h000F_0000_0000_00FF;
  localparam logic [2:0]  DEV_PFX = 3'b101;

  typedef enum logic [2:0] {ST_IDLE, ST_RECV, ST_ACK, ST_SEND, ST_MACK} st_t;
  typedef enum logic [1:0] {PH_ADDR, PH_OFS, PH_DATA} ph_t;

  logic [1:0]         s1, s2, flt, prv;
  logic [1:0][CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '1;
      s2  <= '1;
      flt <= '1;
      prv <= '1;
      cnt <= '0;
    end else begin
      s1  <= {sda_i, scl_i};
      s2  <= s1;
      prv <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i]) cnt[i] <= '0;
        else if (cnt[i] == CW'(FILT_LEN - 1)) begin
          flt[i] <= s2[i];
          cnt[i] <= '0;
        end else cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  logic scl, sda, start_det, stop_det, scl_rise, scl_fall;
  assign scl       = flt[0];
  assign sda       = flt[1];
  assign start_det = prv[0] & scl & prv[1] & ~sda;
  assign stop_det  = prv[0] & scl & ~prv[1] & sda;
  assign scl_rise  = ~prv[0] & scl;
  assign scl_fall  = prv[0] & ~scl;

  st_t        st;
  ph_t        ph;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [2:0] ptr;
  logic       go_rd, nack;
  logic [7:0] rg [NREG];

  logic byte_done, addr_hit, wr_en;
  assign byte_done = (st == ST_RECV) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit  = (shreg[7:1] == {DEV_PFX, strap_i});
  assign wr_en     = byte_done && (ph == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ph     <= PH_ADDR;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      go_rd  <= 1'b0;
      nack   <= 1'b0;
      for (int i = 0; i < NREG; i++) rg[i] <= RST_IMG[8*i +: 8];
    end else if (start_det) begin
      st     <= ST_RECV;
      ph     <= PH_ADDR;
      bitcnt <= '0;
      go_rd  <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_RECV: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_done) begin
            st <= ST_ACK;
            case (ph)
              PH_ADDR: begin
                if (addr_hit) begin
                  go_rd <= shreg[0];
                  ph    <= PH_OFS;
                end else st <= ST_IDLE;
              end
              PH_OFS: begin
                ptr <= shreg[2:0];
                ph  <= PH_DATA;
              end
              default: begin
                rg[ptr] <= shreg;
                ptr     <= ptr + 1'b1;
              end
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (go_rd) begin
            shreg <= rg[ptr];
            st    <= ST_SEND;
          end else st <= ST_RECV;
        end
        ST_SEND: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            st  <= ST_MACK;
            ptr <= ptr + 1'b1;
          end else begin
            shreg  <= {shreg[6:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (scl_rise) nack <= sda;
          if (scl_fall) begin
            if (nack) st <= ST_IDLE;
            else begin
              shreg  <= rg[ptr];
              bitcnt <= '0;
              st     <= ST_SEND;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = (st == ST_ACK) || ((st == ST_SEND) && !shreg[7]);

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[8*g +: 8] = rg[g];
  end
endmodule

// File: rtl/vsplit_i2c_regs_chk.sv
module vsplit_i2c_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic [3:0]  strap_i,
  input logic [63:0] regs_o,
  input logic [2:0]  st,
  input logic [1:0]  ph,
  input logic [2:0]  ptr,
  input logic        wr_en,
  input logic        stop_det
);
  localparam logic [2:0] S_IDLE = 3'd0, S_RECV = 3'd1, S_ACK = 3'd2, S_MACK = 3'd4;
  localparam logic [1:0] P_ADDR = 2'd0, P_OFS = 2'd1;

  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && $past(st) == S_RECV && ph == P_OFS && $past(ph) == P_ADDR)
      |-> ($past(shreg_hi) == {3'b101, $past(strap_i)})); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + 3'd1)); // R3
  AST_MACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK) |-> !sda_oe); // R4
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe); // R5
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o)); // R7

  logic [6:0] shreg_hi;
  assign shreg_hi = u_shreg[7:1];
  logic [7:0] u_shreg;
  assign u_shreg = vsplit_i2c_regs.shreg;
endmodule

bind vsplit_i2c_regs vsplit_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .strap_i(strap_i), .regs_o(regs_o),
  .st(st), .ph(ph), .ptr(ptr), .wr_en(wr_en), .stop_det(stop_det)
);

// File: tb/vsplit_i2c_regs_test.sv
`timescale 1ns/1ps
module vsplit_i2c_regs_test;
  localparam int Q = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] strap = 4'hA;
  logic sda_oe;
  logic [63:0] regs_o;
  wire sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  vsplit_i2c_regs uut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .regs_o(regs_o));

  int checks = 0, failures = 0;
  logic [7:0] mreg [8];
  int mptr = 0;
  bit hold = 1'b1, glitch = 1'b0, done = 1'b0;

  function automatic logic [63:0] mpack();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = mreg[i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !hold && !done) chk(regs_o == mpack(), "R7 per-clock regs", regs_o, mpack());

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask
  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask
  task automatic wbit(input bit b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(Q);
    if (glitch && b) begin sda_m = 1'b0; wq(1); sda_m = 1'b1; end
    wq(Q); scl_m = 1'b0;
    if (glitch) begin wq(Q/2); scl_m = 1'b1; wq(2); scl_m = 1'b0; end
    wq(Q);
  endtask
  task automatic rbit(output bit b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, input bit store, output bit ackb);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0 && store) hold = 1'b1;
      wbit(d[i]);
    end
    if (store) begin mreg[mptr] = d; mptr = (mptr + 1) % 8; hold = 1'b0; end
    rbit(ackb);
  endtask
  task automatic rbyte(input bit last, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(last);
    mptr = (mptr + 1) % 8;
  endtask

  task automatic wr_seq(input logic [2:0] ofs, input int n, input logic [7:0] d0, input string req);
    bit a;
    i2c_start();
    wbyte({3'b101, strap, 1'b0}, 1'b0, a);
    chk(a == 1'b0, "R2 address ack", 64'(a), 64'd0);
    wbyte({5'b0, ofs}, 1'b0, a); mptr = ofs;
    chk(a == 1'b0, "R3 offset ack", 64'(a), 64'd0);
    for (int k = 0; k < n; k++) begin
      wbyte(d0 + 8'(k * 37), 1'b1, a);
      chk(a == 1'b0, req, 64'(a), 64'd0);
    end
    i2c_stop();
  endtask

  task automatic rd_seq(input int n, input string req);
    bit a; logic [7:0] d, e;
    wbyte({3'b101, strap, 1'b1}, 1'b0, a);
    chk(a == 1'b0, "R2 read address ack", 64'(a), 64'd0);
    for (int k = 0; k < n; k++) begin
      e = mreg[mptr];
      rbyte(k == n - 1, d);
      chk(d == e, req, 64'(d), 64'(e));
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    mreg[0] = 8'hFF; mreg[6] = 8'h0F;
    wq(5); rst_n = 1'b1; wq(3);
    chk(regs_o == 64'h000F_0000_0000_00FF, "R1 reset image", regs_o, 64'h000F_0000_0000_00FF);
    chk(sda_oe == 1'b0, "R1 sda released", 64'(sda_oe), 64'd0);
    hold = 1'b0;

    wr_seq(3'd3, 2, 8'h5A, "R3 data ack");
    chk(regs_o[31:24] == 8'h5A, "R3 reg3", 64'(regs_o[31:24]), 64'h5A);

    begin : wrong_addr
      bit a;
      i2c_start();
      wbyte({3'b101, 4'hB, 1'b0}, 1'b0, a);
      chk(a == 1'b1, "R2 foreign address nack", 64'(a), 64'd1);
      wbyte(8'h02, 1'b0, a);
      chk(a == 1'b1, "R2 ignored after mismatch", 64'(a), 64'd1);
      wbyte(8'h11, 1'b0, a);
      i2c_stop();
      chk(regs_o == mpack(), "R2 regs untouched", regs_o, mpack());
    end

    wr_seq(3'd6, 3, 8'h12, "R3 wrap ack");
    chk(regs_o[7:0] == 8'h12 + 8'd74, "R3 wrap to 0", 64'(regs_o[7:0]), 64'(8'h12 + 8'd74));

    wr_seq(3'd2, 0, 8'h00, "R7");
    chk(regs_o == mpack(), "R7 offset only", regs_o, mpack());

    i2c_start(); rd_seq(3, "R4 read data"); i2c_stop();
    chk(sda_oe == 1'b0, "R4 released after nack", 64'(sda_oe), 64'd0);

    begin : restart
      bit a;
      i2c_start();
      wbyte({3'b101, strap, 1'b0}, 1'b0, a);
      wbyte(8'h07, 1'b0, a); mptr = 7;
      i2c_start();
      rd_seq(2, "R5 repeated start read wrap");
      i2c_stop();
    end

    strap = 4'h3;
    glitch = 1'b1;
    wr_seq(3'd1, 1, 8'h9B, "R6 ack under glitches");
    glitch = 1'b0;
    chk(regs_o[15:8] == 8'h9B, "R6 reg1 under glitches", 64'(regs_o[15:8]), 64'h9B);

    begin : midstop
      bit a;
      i2c_start();
      wbyte({3'b101, strap, 1'b0}, 1'b0, a);
      wbyte(8'h04, 1'b0, a); mptr = 4;
      for (int i = 0; i < 4; i++) wbit(1'b0);
      i2c_stop();
      chk(regs_o == mpack(), "R5 partial byte dropped", regs_o, mpack());
      i2c_start(); rd_seq(1, "R5 pointer kept after stop"); i2c_stop();
    end

    wq(10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule